// File: doc/BRIEF.md
# Double-Buffered Nine-Bit Serial Transmitter

This block is the transmit side of an asynchronous serial port. Software writes a data byte, and separately a ninth-bit value, through a plain strobe interface. The block then shifts a frame out on `txd`, one bit per period of an externally supplied `baud_tick` pulse. A frame is a low start bit, the data bits least-significant first, an optional ninth bit, and a high stop bit. A frame-format input selects either eight or nine data bits.

A control input turns a one-entry holding register on or off, and the meaning of the transmit flag `ti_flag` depends on it. With the holding register off, the flag marks the end of a frame, and the ninth bit is taken live from its register at the moment it is shifted out. With the holding register on, the flag means "room for another byte". The ninth bit then travels with the byte that was written, and a queued byte follows the previous stop bit with no idle time between the frames. A write that finds no free storage is dropped and sets a sticky overrun flag.

Top module: `uart9_tx_db`

## Requirements
- R1: After reset, and whenever no frame is in flight, `txd` is 1. After reset, `ti_flag` and `overrun` are 0.
- R2: A frame is a 0 start bit, then `wr_byte[0]` through `wr_byte[7]`, then a 1 stop bit. The first bit starts at the first `baud_tick` after the byte is accepted. `txd` changes only at a clock edge where `baud_tick` is 1, so every bit lasts exactly one tick period.
- R3: When `nine_bit`=1, the ninth bit is sent between data bit 7 and the stop bit. When `nine_bit`=0, it is left out of the frame.
- R4: When `dbuf_en`=0, `ti_flag` goes to 1 at the tick edge that ends the stop bit, and not before.
- R5: When `dbuf_en`=0, the ninth bit sent is the value held in the ninth-bit register (loaded by `wr_bit9` with `bit9_in`) at the tick where that bit begins. A change made after the byte write still takes effect.
- R6: When `dbuf_en`=1, a byte written while both the shifter and the holding register are empty goes straight to the shifter, and `ti_flag` is 1 from the clock edge that accepts the write. A byte that lands in the holding register does not set `ti_flag`.
- R7: When `dbuf_en`=1, the ninth bit is captured from the ninth-bit register at the byte write. A later change does not affect that frame.
- R8: When `dbuf_en`=1 and a byte waits in the holding register, the byte moves into the shifter at the tick that ends the current stop bit. Its start bit begins at that same tick, so no idle bit separates the frames, and `ti_flag` goes to 1 at that edge.
- R9: `ti_flag` stays at 1 until a `clr_ti` pulse clears it. If a new flag event and `clr_ti` occur in the same cycle, the flag ends up at 1.
- R10: A byte write is dropped when no storage is free. With `dbuf_en`=1 that means the holding register is full; with `dbuf_en`=0 it means a frame is in flight. A dropped write is never sent and sets `overrun`, which stays at 1 until a `clr_ovr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| nine_bit | input | 1 | 1 = nine data bits per frame, 0 = eight |
| dbuf_en | input | 1 | 1 = holding register in use |
| wr_data | input | 1 | Data byte write strobe |
| wr_byte | input | 8 | Byte to send |
| wr_bit9 | input | 1 | Ninth-bit register write strobe |
| bit9_in | input | 1 | Value for the ninth-bit register |
| clr_ti | input | 1 | Clear pulse for `ti_flag` |
| clr_ovr | input | 1 | Clear pulse for `overrun` |
| txd | output | 1 | Serial line, idles high |
| ti_flag | output | 1 | Transmit flag (frame done or buffer free, depending on mode) |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
The flags are due at fixed edges. In buffered mode, `ti_flag` and `overrun` take their new values at the same edge that accepts the write, so the bench reads them right after that edge. At the end of a frame, or on the hand-off from the holding register, `ti_flag` rises exactly one tick after the stop bit appears on the line. The bench therefore waits for the first cycle with `ti_flag` set, then confirms three things: the previous frame has just been decoded, a tick edge has just passed, and `txd` shows either idle or the next start bit. The line is decoded one cycle after each tick edge. On every other cycle the bench checks that `txd` has not moved.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned MAX_BIT = DATA_W + 2;          // start .. stop with ninth bit
  localparam int unsigned IDX_W   = $clog2(MAX_BIT + 1);

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              b9;
  } tx_word_t;

  // Position of the stop bit for the chosen frame format.
  function automatic logic [IDX_W-1:0] stop_pos(input logic nine);
    return nine ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
  endfunction

  // Line level for bit position idx of a frame (0 = start bit).
  function automatic logic frame_bit(input logic [IDX_W-1:0] idx,
                                     input logic [DATA_W-1:0] data,
                                     input logic b9,
                                     input logic nine);
    logic [IDX_W-1:0] dpos;
    dpos = idx - IDX_W'(1);
    if (idx == '0)                                return 1'b0;
    else if (idx <= IDX_W'(DATA_W))               return data[dpos[$clog2(DATA_W)-1:0]];
    else if (nine && (idx == IDX_W'(DATA_W + 1))) return b9;
    else                                          return 1'b1;
  endfunction
endpackage

// File: rtl/uart9_hold.sv
module uart9_hold
  import uart9_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  tx_word_t word_in,
  input  logic     take,
  output logic     full,
  output tx_word_t word_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full     <= 1'b0;
      word_out <= '0;
    end else if (wr) begin
      full     <= 1'b1;
      word_out <= word_in;
    end else if (take) begin
      full     <= 1'b0;
    end
  end

  // A full entry is kept intact until it is handed to the shifter.
  p_hold_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(word_out)));
  // The write path never targets an occupied entry.
  p_no_clobber_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && full));
endmodule

// File: rtl/uart9_shifter.sv
module uart9_shifter
  import uart9_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     baud_tick,
  input  logic     load,
  input  tx_word_t load_word,
  input  logic     load_nine,
  input  logic     live_b9,
  input  logic     use_live,
  output logic     txd,
  output logic     loaded,
  output logic     frame_end
);
  logic             started;
  logic [IDX_W-1:0] idx;
  tx_word_t         word;
  logic             nine;
  logic [IDX_W-1:0] idx_nx;
  logic             b9_now;

  assign idx_nx    = idx + IDX_W'(1);
  assign b9_now    = use_live ? live_b9 : word.b9;
  assign frame_end = baud_tick && started && (idx == stop_pos(nine));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded  <= 1'b0;
      started <= 1'b0;
      idx     <= '0;
      word    <= '0;
      nine    <= 1'b0;
      txd     <= 1'b1;
    end else if (baud_tick && started) begin
      if (frame_end) begin
        if (load) begin            // back-to-back frame: start bit now
          word <= load_word;
          nine <= load_nine;
          idx  <= '0;
          txd  <= 1'b0;
        end else begin
          loaded  <= 1'b0;
          started <= 1'b0;
          idx     <= '0;
          txd     <= 1'b1;
        end
      end else begin
        idx <= idx_nx;
        txd <= frame_bit(idx_nx, word.data, b9_now, nine);
      end
    end else begin
      if (load) begin
        loaded <= 1'b1;
        word   <= load_word;
        nine   <= load_nine;
      end
      if (loaded && baud_tick && !started) begin
        started <= 1'b1;
        idx     <= '0;
        txd     <= 1'b0;
      end
    end
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> txd);
  p_bit_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> !txd);
  p_load_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!loaded || frame_end));
endmodule

// File: rtl/uart9_flags.sv
module uart9_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ti_set,
  input  logic ti_clr,
  input  logic ovr_set,
  input  logic ovr_clr,
  output logic ti,
  output logic ovr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ti  <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (ti_set)       ti  <= 1'b1;   // a new event beats a clear
      else if (ti_clr)  ti  <= 1'b0;
      if (ovr_set)      ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end

  p_ti_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ti_set |=> ti);
  p_ti_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !ti_clr) |=> ti);
  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr && !ovr_clr) || ovr_set) |=> ovr);
endmodule

// File: rtl/uart9_tx_db.sv
module uart9_tx_db
  import uart9_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              nine_bit,
  input  logic              dbuf_en,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              wr_bit9,
  input  logic              bit9_in,
  input  logic              clr_ti,
  input  logic              clr_ovr,
  output logic              txd,
  output logic              ti_flag,
  output logic              overrun
);
  logic     b9_reg;
  logic     sh_loaded, frame_end, hold_full;
  tx_word_t hold_word, wr_word, sh_word_in;
  logic     load_direct, hold_wr, hold_take, sh_load, ti_evt, ovr_evt;

  always_ff @(posedge clk) begin
    if (!rst_n)       b9_reg <= 1'b0;
    else if (wr_bit9) b9_reg <= bit9_in;
  end

  // Named internal events
  assign wr_word     = '{data: wr_byte, b9: b9_reg};
  assign load_direct = wr_data && !sh_loaded && !hold_full;
  assign hold_wr     = wr_data && dbuf_en && sh_loaded && !hold_full;
  assign hold_take   = hold_full && (frame_end || !sh_loaded);
  assign sh_load     = load_direct || hold_take;
  assign sh_word_in  = hold_take ? hold_word : wr_word;
  assign ovr_evt     = wr_data && !load_direct && !hold_wr;
  assign ti_evt      = dbuf_en ? sh_load : frame_end;

  uart9_hold u_hold (
    .clk(clk), .rst_n(rst_n), .wr(hold_wr), .word_in(wr_word),
    .take(hold_take), .full(hold_full), .word_out(hold_word)
  );

  uart9_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(sh_load),
    .load_word(sh_word_in), .load_nine(nine_bit), .live_b9(b9_reg),
    .use_live(!dbuf_en), .txd(txd), .loaded(sh_loaded), .frame_end(frame_end)
  );

  uart9_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ti_set(ti_evt), .ti_clr(clr_ti),
    .ovr_set(ovr_evt), .ovr_clr(clr_ovr), .ti(ti_flag), .ovr(overrun)
  );

  p_buf_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && wr_data && !sh_loaded && !hold_full) |=> ti_flag);
  p_ovr_on_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !dbuf_en && sh_loaded) |=> overrun);
endmodule

// File: tb/uart9_tx_db_tb.sv
module uart9_tx_db_tb;
  localparam int BP = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic       rst_n = 1'b0;
  logic       nine_bit = 1'b0, dbuf_en = 1'b0, wr_data = 1'b0, wr_bit9 = 1'b0;
  logic       bit9_in = 1'b0, clr_ti = 1'b0, clr_ovr = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       txd, ti_flag, overrun, baud_tick;

  logic [3:0] phase = 4'd0;
  always @(posedge clk) phase <= (phase == BP - 1) ? 4'd0 : phase + 4'd1;
  assign baud_tick = (phase == 4'd0);

  uart9_tx_db u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .nine_bit(nine_bit),
    .dbuf_en(dbuf_en), .wr_data(wr_data), .wr_byte(wr_byte), .wr_bit9(wr_bit9),
    .bit9_in(bit9_in), .clr_ti(clr_ti), .clr_ovr(clr_ovr), .txd(txd),
    .ti_flag(ti_flag), .overrun(overrun)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- line monitor (decodes at each tick edge) -------------
  logic [7:0] rx_d[64];
  logic       rx_b[64];
  int         rx_gap[64];
  int         rx_n = 0;
  int         mon_st = 0, mon_cnt = 0, idle_cnt = 100, cur_gap = 0;
  logic [8:0] mon_sh = '0;
  logic       prev_txd = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (txd !== prev_txd && phase != 4'd1) begin
        checks++; errors++;
        $display("FAIL R2 txd moved off tick actual=%0b expected=%0b", txd, prev_txd);
      end
      if (phase == 4'd1) begin
        if (mon_st == 0) begin
          if (txd == 1'b0) begin mon_st = 1; mon_cnt = 0; cur_gap = idle_cnt; mon_sh = '0; end
          else idle_cnt++;
        end else if (mon_cnt < (nine_bit ? 9 : 8)) begin
          mon_sh[mon_cnt] = txd;
          mon_cnt++;
        end else begin
          chk("R2 stop bit", int'(txd), 1);
          rx_d[rx_n & 63] = mon_sh[7:0];
          rx_b[rx_n & 63] = nine_bit ? mon_sh[8] : 1'b0;
          rx_gap[rx_n & 63] = cur_gap;
          rx_n++;
          mon_st = 0;
          idle_cnt = 0;
        end
      end
    end
    prev_txd = txd;
  end

  // ---------------- helpers ----------------
  function automatic int exp_b9(input logic nine, input logic b);
    return nine ? int'(b) : 0;
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_data = 1'b1; wr_byte = d; step(); wr_data = 1'b0;
  endtask

  task automatic set_b9(input logic v);
    wr_bit9 = 1'b1; bit9_in = v; step(); wr_bit9 = 1'b0;
  endtask

  task automatic pulse_clr_ti();
    clr_ti = 1'b1; step(); clr_ti = 1'b0;
  endtask

  task automatic pulse_clr_ovr();
    clr_ovr = 1'b1; step(); clr_ovr = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin step(); if (phase == 4'd1) k++; end
  endtask

  task automatic wait_frames(input int n);
    int lim = 0;
    while (rx_n < n && lim < 2000) begin step(); lim++; end
    wait_ticks(2);
  endtask

  task automatic wait_ti();
    int lim = 0;
    while (!ti_flag && lim < 2000) begin step(); lim++; end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int base;
    void'($urandom(32'd1357));
    repeat (4) step();
    chk("R1 reset txd", int'(txd), 1);
    chk("R1 reset ti", int'(ti_flag), 0);
    chk("R1 reset overrun", int'(overrun), 0);
    rst_n = 1'b1;
    wait_ticks(2);
    chk("R1 idle txd", int'(txd), 1);

    // R2: eight-bit frame, unbuffered
    base = rx_n;
    wr(8'hA5);
    wait_frames(base + 1);
    chk("R2 data", int'(rx_d[base]), 8'hA5);

    // R4: flag at the tick ending the stop bit
    pulse_clr_ti();
    chk("R4 cleared", int'(ti_flag), 0);
    base = rx_n;
    wr(8'h3C);
    wait_ti();
    chk("R4 frame done at flag", rx_n, base + 1);
    chk("R4 flag on tick edge", int'(phase == 4'd1), 1);
    chk("R4 line idle", int'(txd), 1);
    wait_ticks(2);

    // R3 + R5: nine-bit, unbuffered, ninth bit changed after the write
    nine_bit = 1'b1;
    set_b9(1'b0);
    base = rx_n;
    wr(8'h81);
    set_b9(1'b1);
    wait_frames(base + 1);
    chk("R3 data", int'(rx_d[base]), 8'h81);
    chk("R5 live ninth bit", int'(rx_b[base]), 1);

    // R6 + R7: buffered, ninth bit captured at the write
    dbuf_en = 1'b1;
    set_b9(1'b1);
    pulse_clr_ti();
    chk("R6 flag clear before", int'(ti_flag), 0);
    base = rx_n;
    wr(8'h5A);
    chk("R6 flag at write", int'(ti_flag), 1);
    set_b9(1'b0);
    wait_frames(base + 1);
    chk("R7 captured ninth bit", int'(rx_b[base]), 1);
    chk("R7 data", int'(rx_d[base]), 8'h5A);

    // R8 + R10: queued frame, then a dropped write
    nine_bit = 1'b0;
    pulse_clr_ti();
    base = rx_n;
    wr(8'h11);
    chk("R6 direct load flag", int'(ti_flag), 1);
    pulse_clr_ti();
    wr(8'h22);
    chk("R6 hold full no flag", int'(ti_flag), 0);
    chk("R10 no overrun yet", int'(overrun), 0);
    wr(8'h33);
    chk("R10 overrun set", int'(overrun), 1);
    repeat (5) step();
    chk("R10 overrun sticky", int'(overrun), 1);
    wait_ti();
    chk("R8 first frame done at flag", rx_n, base + 1);
    chk("R8 flag on tick edge", int'(phase == 4'd1), 1);
    chk("R8 next start bit at once", int'(txd), 0);
    wait_frames(base + 2);
    wait_ticks(14);
    chk("R10 dropped byte not sent", rx_n, base + 2);
    chk("R8 data 1", int'(rx_d[base]), 8'h11);
    chk("R8 data 2", int'(rx_d[base + 1]), 8'h22);
    chk("R8 no idle gap", rx_gap[base + 1], 0);
    pulse_clr_ovr();
    chk("R10 overrun cleared", int'(overrun), 0);

    // R9: hold and set-beats-clear
    chk("R9 flag held", int'(ti_flag), 1);
    pulse_clr_ti();
    chk("R9 flag cleared", int'(ti_flag), 0);
    base = rx_n;
    wr_data = 1'b1; wr_byte = 8'h77; clr_ti = 1'b1;
    step();
    wr_data = 1'b0; clr_ti = 1'b0;
    chk("R9 set beats clear", int'(ti_flag), 1);
    repeat (3) step();
    chk("R9 flag stays", int'(ti_flag), 1);
    wait_frames(base + 1);
    chk("R9 data", int'(rx_d[base]), 8'h77);

    // R10: unbuffered drop while busy
    dbuf_en = 1'b0;
    base = rx_n;
    wr(8'h44);
    wr(8'h55);
    chk("R10 unbuffered overrun", int'(overrun), 1);
    wait_frames(base + 1);
    wait_ticks(14);
    chk("R10 unbuffered one frame", rx_n, base + 1);
    chk("R10 unbuffered data", int'(rx_d[base]), 8'h44);
    pulse_clr_ovr();

    // Random frames (R2/R3)
    for (int i = 0; i < 16; i++) begin
      logic       n9, db, b;
      logic [7:0] d;
      n9 = 1'($urandom % 2); db = 1'($urandom % 2);
      b = 1'($urandom % 2); d = 8'($urandom);
      nine_bit = n9; dbuf_en = db;
      set_b9(b);
      base = rx_n;
      wr(d);
      wait_frames(base + 1);
      chk("R2 random data", int'(rx_d[base]), int'(d));
      chk("R3 random ninth bit", int'(rx_b[base]), exp_b9(n9, b));
    end
    chk("R10 no stray overrun", int'(overrun), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule